// File: doc/BRIEF.md
# Volume Envelope Generator

This block produces the 4-bit loudness level of one tone channel and moves it up or down by one step at a programmable rate. Software writes an 8-bit setup byte holding a starting level, a direction flag and a 3-bit step interval. A trigger pulse then loads the level and the interval countdown. Each strobe on the envelope-clock input counts the interval down. When the countdown expires it reloads and the level moves one step.

The level never wraps. Rising stops at 15 and falling stops at 0. An interval of zero freezes the level completely. The setup byte reads back unchanged. The envelope clock comes from outside the block.

Top module: `vol_env`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the setup byte, the level and the interval countdown all clear to zero, so `vol_out` and `cfg_rdata` read 0 in the cycle after.
- R2: A `cfg_wr` pulse stores `cfg_wdata` whole, and `cfg_rdata` returns it from the next cycle on (0xF3 reads back as 0xF3). Bits 7:4 are the starting level, bit 3 is the direction (1 = rise, 0 = fall) and bits 2:0 are the step interval.
- R3: A `trig` pulse loads the level from the stored starting level and the countdown from the stored interval. A setup write in the same cycle does not affect that trigger.
- R4: While the stored interval is zero, `env_tick` pulses leave the level unchanged.
- R5: With a non-zero interval, each `env_tick` decrements a countdown that is above 1 and leaves the level alone. A tick that finds the countdown at 1 or 0 reloads it with the interval and steps the level once, so an interval of N steps once every N ticks after a trigger.
- R6: A step adds one to the level when the direction bit is 1 and subtracts one when it is 0.
- R7: A rising level holds at 15 and a falling level holds at 0; it never wraps.
- R8: When `trig` and `env_tick` are high in the same cycle, the trigger takes effect and the tick is discarded.
- R9: Without a trigger or a stepping tick, the level holds its value, even across setup writes.
- R10: If a trigger loaded the countdown with zero and a non-zero interval is written afterwards, the very next tick steps the level and reloads the countdown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-off) |
| cfg_wr | input | 1 | Setup byte write strobe |
| cfg_wdata | input | 8 | Setup byte: level[7:4], direction[3], interval[2:0] |
| cfg_rdata | output | 8 | Stored setup byte |
| trig | input | 1 | Trigger pulse that restarts the envelope |
| env_tick | input | 1 | Envelope clock strobe, one cycle per step tick |
| vol_out | output | 4 | Current level |

## Verification
A countdown that is off by one moves the first level change to a different tick after a trigger. The vectors therefore check the level after exact tick counts, including counts one short of a step. A saturation error appears as a jump to 0 or 15 on the tick after the level reaches its limit. A dropped priority or a stale countdown shows up on the first tick after a combined trigger and tick, or after a zero-interval trigger. A corrupted setup register is visible on `cfg_rdata` in the cycle after the write.

// File: rtl/env_pkg.sv
// Shared defaults and types for the volume envelope.
// Assumes one setup byte made of level, direction and interval fields.
package env_pkg;
    localparam int ENV_VOL_W = 4;
    localparam int ENV_PER_W = 3;

    typedef enum logic {
        DIR_FALL = 1'b0,
        DIR_RISE = 1'b1
    } env_dir_e;
endpackage

// File: rtl/env_cfg_reg.sv
// Setup register: holds level, direction and interval and returns them unchanged.
// Assumes a single-cycle write strobe; the new value is visible the next cycle.
module env_cfg_reg #(
    parameter int VOL_W = 4,
    parameter int PER_W = 3,
    localparam int CFG_W = VOL_W + 1 + PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CFG_W-1:0] wdata,
    output logic [CFG_W-1:0] rdata,
    output logic [VOL_W-1:0] init_vol,
    output env_pkg::env_dir_e dir,
    output logic [PER_W-1:0] period
);
    logic [CFG_W-1:0] cfg_q;

    // Store the whole setup byte on a write and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)     cfg_q <= '0;
        else if (wr_en) cfg_q <= wdata;
    end

    // Split the stored byte into its fields.
    always_comb begin
        rdata    = cfg_q;
        init_vol = cfg_q[CFG_W-1 -: VOL_W];
        dir      = env_pkg::env_dir_e'(cfg_q[PER_W]);
        period   = cfg_q[PER_W-1:0];
    end
endmodule

// File: rtl/env_timer.sv
// Interval countdown: produces a one-cycle step request every `period` ticks.
// Assumes that trig overrides tick and that a zero period disables stepping.
module env_timer #(
    parameter int PER_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig,
    input  logic             tick,
    input  logic [PER_W-1:0] period,
    output logic             step
);
    logic [PER_W-1:0] cnt_q;
    logic             live;

    // Decide whether this tick counts and whether it expires the countdown.
    always_comb begin
        live = tick && !trig && (period != '0);
        step = live && (cnt_q <= PER_W'(1));
    end

    // Load on trigger, otherwise count down and reload when a step is taken.
    always_ff @(posedge clk) begin
        if (!rst_n)    cnt_q <= '0;
        else if (trig) cnt_q <= period;
        else if (step) cnt_q <= period;
        else if (live) cnt_q <= cnt_q - PER_W'(1);
    end
endmodule

// File: rtl/env_level.sv
// Level register: loads on trigger and moves one step with saturation.
// Assumes that step is never high while trig is high.
module env_level #(
    parameter int VOL_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trig,
    input  logic              step,
    input  env_pkg::env_dir_e dir,
    input  logic [VOL_W-1:0]  init_vol,
    output logic [VOL_W-1:0]  vol
);
    localparam logic [VOL_W-1:0] VMAX = '1;
    localparam logic [VOL_W-1:0] VMIN = '0;

    logic [VOL_W-1:0] vol_q;
    logic [VOL_W-1:0] vol_step;

    // Work out the next level for a step, holding at either limit.
    always_comb begin
        if (dir == env_pkg::DIR_RISE)
            vol_step = (vol_q == VMAX) ? vol_q : vol_q + VOL_W'(1);
        else
            vol_step = (vol_q == VMIN) ? vol_q : vol_q - VOL_W'(1);
    end

    // Update the level on trigger or step and clear it on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)    vol_q <= '0;
        else if (trig) vol_q <= init_vol;
        else if (step) vol_q <= vol_step;
    end

    assign vol = vol_q;
endmodule

// File: rtl/vol_env.sv
// Volume envelope top: setup register, interval countdown and level register.
// Assumes the envelope clock strobe and trigger are single-cycle pulses in the clk domain.
module vol_env #(
    parameter int VOL_W = env_pkg::ENV_VOL_W,
    parameter int PER_W = env_pkg::ENV_PER_W,
    localparam int CFG_W = VOL_W + 1 + PER_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_wdata,
    output logic [CFG_W-1:0] cfg_rdata,
    input  logic             trig,
    input  logic             env_tick,
    output logic [VOL_W-1:0] vol_out
);
    logic [VOL_W-1:0]  init_vol;
    logic [PER_W-1:0]  period;
    env_pkg::env_dir_e dir;
    logic              step;

    env_cfg_reg #(.VOL_W(VOL_W), .PER_W(PER_W)) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .init_vol (init_vol),
        .dir      (dir),
        .period   (period)
    );

    env_timer #(.PER_W(PER_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .trig   (trig),
        .tick   (env_tick),
        .period (period),
        .step   (step)
    );

    env_level #(.VOL_W(VOL_W)) u_level (
        .clk      (clk),
        .rst_n    (rst_n),
        .trig     (trig),
        .step     (step),
        .dir      (dir),
        .init_vol (init_vol),
        .vol      (vol_out)
    );
endmodule

// File: rtl/vol_env_chk.sv
// Port-level property checker for vol_env, attached with bind.
// Assumes the field layout level[top], direction[PER_W], interval[low].
module vol_env_chk #(
    parameter int VOL_W = 4,
    parameter int PER_W = 3,
    localparam int CFG_W = VOL_W + 1 + PER_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic [CFG_W-1:0] cfg_wdata,
    input logic [CFG_W-1:0] cfg_rdata,
    input logic             trig,
    input logic             env_tick,
    input logic [VOL_W-1:0] vol_out
);
    localparam logic [VOL_W-1:0] VMAX = '1;

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (vol_out == '0) && (cfg_rdata == '0));

    p_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> cfg_rdata == $past(cfg_wdata));

    p_trig_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        trig |=> vol_out == $past(cfg_rdata[CFG_W-1 -: VOL_W]));

    p_zero_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && cfg_rdata[PER_W-1:0] == '0) |=> $stable(vol_out));

    p_no_wrap_hi_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && vol_out == VMAX && cfg_rdata[PER_W]) |=> vol_out == VMAX);

    p_no_wrap_lo_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && vol_out == '0 && !cfg_rdata[PER_W]) |=> vol_out == '0);

    p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!trig && !env_tick) |=> $stable(vol_out));
endmodule

bind vol_env vol_env_chk #(.VOL_W(VOL_W), .PER_W(PER_W)) u_vol_env_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wr    (cfg_wr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .trig      (trig),
    .env_tick  (env_tick),
    .vol_out   (vol_out)
);

// File: tb/test_vol_env.sv
`timescale 1ns/1ps
module test_vol_env;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       trig = 1'b0;
    logic       env_tick = 1'b0;
    logic [3:0] vol_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    vol_env i_vol_env (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .trig(trig), .env_tick(env_tick), .vol_out(vol_out)
    );

    // Vector: {setup byte, tick count after trigger, expected level}.
    localparam int NV = 11;
    localparam logic [19:0] VEC [NV] = '{
        {8'hF3, 8'd6,  4'd13},  // R5 R6 fall, interval 3
        {8'hF3, 8'd2,  4'd15},  // R5 one short of a step
        {8'h79, 8'd1,  4'd8},   // R6 rise, interval 1
        {8'h71, 8'd1,  4'd6},   // R6 fall, interval 1
        {8'hA2, 8'd1,  4'd10},  // R5 countdown 2 -> 1, no step
        {8'hA2, 8'd2,  4'd9},   // R5 step on second tick
        {8'h57, 8'd14, 4'd3},   // R5 interval 7, two steps
        {8'h3D, 8'd60, 4'd15},  // R7 rise saturates
        {8'h29, 8'd20, 4'd15},  // R7 rise saturates, interval 1
        {8'h21, 8'd5,  4'd0},   // R7 fall saturates at 0
        {8'hC8, 8'd10, 4'd12}   // R4 interval zero freezes
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_wr(input logic [7:0] d);
        @(negedge clk); cfg_wr = 1'b1; cfg_wdata = d;
        @(negedge clk); cfg_wr = 1'b0;
    endtask

    task automatic do_trig();
        @(negedge clk); trig = 1'b1;
        @(negedge clk); trig = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk); env_tick = 1'b1;
            @(negedge clk); env_tick = 1'b0;
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset level", {4'h0, vol_out}, 8'h00);
        check("R1 reset setup", cfg_rdata, 8'h00);
        rst_n = 1'b1;

        // Table walk: write, check readback, trigger, tick, check level.
        for (int i = 0; i < NV; i++) begin
            do_wr(VEC[i][19:12]);
            check("R2 readback", cfg_rdata, VEC[i][19:12]);
            do_trig();
            check("R3 trigger load", {4'h0, vol_out}, {4'h0, VEC[i][19:16]});
            do_ticks(int'(VEC[i][11:4]));
            check("R5/R6/R7/R4 level", {4'h0, vol_out}, {4'h0, VEC[i][3:0]});
        end

        // R8: trigger and tick together, trigger wins and reloads countdown.
        do_wr(8'hF1);
        do_trig();
        do_ticks(3);
        check("R6 level before combined", {4'h0, vol_out}, 8'h0C);
        @(negedge clk); trig = 1'b1; env_tick = 1'b1;
        @(negedge clk); trig = 1'b0; env_tick = 1'b0;
        check("R8 trigger priority", {4'h0, vol_out}, 8'h0F);
        do_ticks(1);
        check("R8 countdown reloaded", {4'h0, vol_out}, 8'h0E);

        // R3: write in the trigger cycle does not change that trigger.
        do_wr(8'h40);
        @(negedge clk); trig = 1'b1; cfg_wr = 1'b1; cfg_wdata = 8'h90;
        @(negedge clk); trig = 1'b0; cfg_wr = 1'b0;
        check("R3 old setup used", {4'h0, vol_out}, 8'h04);

        // R10: zero countdown then non-zero interval steps at once.
        do_wr(8'h80);
        do_trig();
        do_ticks(1);
        check("R4 zero interval tick", {4'h0, vol_out}, 8'h08);
        do_wr(8'h81);
        check("R9 write keeps level", {4'h0, vol_out}, 8'h08);
        do_ticks(1);
        check("R10 immediate step", {4'h0, vol_out}, 8'h07);
        do_ticks(1);
        check("R10 reload after step", {4'h0, vol_out}, 8'h06);
        do_wr(8'hF0);
        repeat (4) @(negedge clk);
        check("R9 hold without tick", {4'h0, vol_out}, 8'h06);

        // R1: reset in mid-run clears everything.
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 mid-run reset level", {4'h0, vol_out}, 8'h00);
        check("R1 mid-run reset setup", cfg_rdata, 8'h00);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule